// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the synchronous bus port of a byte-wide NOR-style flash and its internal operation engine. It watches every bus write and tracks unlock-prefixed command sequences. A finished byte-program or chip-erase sequence becomes a single-cycle start request, carrying the operation kind, the address and the data. The decoder does not contain the memory array, and it does not time the program or erase pulses.

The decoder also tracks a sticky identification mode. A dedicated command enters this mode, and the reset command byte leaves it. While the mode is active, bus reads are answered by the decoder: the low address byte selects the manufacturer code or the device code, and a read with the two lowest address bits equal to 1,0 returns the protect bit of the sector picked by the top address bits. Outside this mode the decoder does not answer reads, so the array path answers them.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The two unlock writes are data AAh at command address 555h, then data 55h at command address 2AAh. The command byte that follows must also be written at 555h. Only the low 11 address bits are compared. A command byte written at any other address starts no operation and enters no mode.
- R2: Unlock, unlock, then A0h, then one more write of any address and data. One cycle after that last write, `op_start` is high for one cycle, `op_kind` is 0 (program), and `op_addr` and `op_data` hold the address and data of that last write.
- R3: Unlock, unlock, 80h, unlock, unlock, then 10h. One cycle after the final write, `op_start` pulses with `op_kind` = 1 (erase).
- R4: A program data write whose sector (address bits 16..14) has its bit set in `sect_prot` produces no `op_start`. The sequencer then returns to idle.
- R5: A write that does not match the next step expected in a sequence drops the partial sequence. It issues no operation, and a later complete sequence is decoded normally.
- R6: Unlock, unlock, then 90h sets `asel_mode` from the next cycle onward. The mode stays set through any other writes, including a complete program sequence.
- R7: In identification mode, a read whose low address byte is 00h returns 01h, and a read whose low address byte is 01h returns 20h. `rd_valid` is high and `rd_data` is valid one cycle after `bus_rd`.
- R8: Every identification code read back has odd parity over its eight bits, and bit 7 acts as the parity bit.
- R9: In identification mode, a read with address bits 1,0 = 1,0 (and a low byte other than 00h or 01h) returns the sector's `sect_prot` bit on bit 0, with zeros elsewhere.
- R10: Data F0h written at any address, in any state other than awaiting program data, clears `asel_mode` and aborts any partial sequence.
- R11: Outside identification mode a read leaves `rd_valid` low.
- R12: `op_start` never stays high for two cycles in a row. `op_addr` and `op_data` hold their values until the next accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per bus write |
| bus_rd | input | 1 | Read strobe, one cycle per bus read |
| bus_addr | input | 17 | Byte address |
| bus_wdata | input | 8 | Write data |
| sect_prot | input | 8 | Protect flag per sector, one bit per sector |
| asel_mode | output | 1 | Identification mode active |
| rd_valid | output | 1 | Decoder supplies read data this cycle |
| rd_data | output | 8 | Identification or protect read value |
| op_start | output | 1 | One-cycle operation start request |
| op_kind | output | 1 | 0 = byte program, 1 = chip erase |
| op_addr | output | 17 | Program address |
| op_data | output | 8 | Program data (FFh for erase) |

## Verification
Each result of the block appears exactly one clock edge after the strobe that causes it. `op_start` and the operation fields follow the final write of a sequence. `rd_valid` and `rd_data` follow the read strobe. `asel_mode` changes one edge after the mode or reset command. The bench drives each strobe on a falling edge, holds it across one rising edge, removes it on the next falling edge, and samples every output there. Each result is therefore observed in the single cycle in which it is due. A result that comes early or late is not merely tolerated: it fails.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PROG,
    S_ERS1,
    S_ERS2,
    S_ERS3
  } seq_state_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  localparam logic [7:0] K_UNLOCK_A  = 8'hAA;
  localparam logic [7:0] K_UNLOCK_B  = 8'h55;
  localparam logic [7:0] K_PROG_SET  = 8'hA0;
  localparam logic [7:0] K_ERASE_SET = 8'h80;
  localparam logic [7:0] K_CHIP_ERS  = 8'h10;
  localparam logic [7:0] K_IDENT     = 8'h90;
  localparam logic [7:0] K_RESET     = 8'hF0;

  localparam logic [15:0] A_UNLOCK_A = 16'h0555;
  localparam logic [15:0] A_UNLOCK_B = 16'h02AA;

  // Bit 7 is chosen so that the whole byte has an odd number of ones.
  function automatic logic [7:0] odd_code(input logic [6:0] c);
    return {~(^c), c};
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              prog_evt,
  output logic              erase_evt,
  output logic              asel_evt,
  output logic              reset_evt,
  output seq_state_e        state_o
);

  localparam logic [CMD_AW-1:0] LA = A_UNLOCK_A[CMD_AW-1:0];
  localparam logic [CMD_AW-1:0] LB = A_UNLOCK_B[CMD_AW-1:0];

  seq_state_e state_q, state_d;
  logic [CMD_AW-1:0] low;
  logic hit_a, hit_b;

  function automatic logic cmd_is(input logic [CMD_AW-1:0] a,
                                  input logic [7:0] d,
                                  input logic [7:0] k);
    return (a == LA) && (d == k);
  endfunction

  assign low   = wr_addr[CMD_AW-1:0];
  assign hit_a = cmd_is(low, wr_data, K_UNLOCK_A);
  assign hit_b = (low == LB) && (wr_data == K_UNLOCK_B);

  always_comb begin
    state_d   = state_q;
    prog_evt  = 1'b0;
    erase_evt = 1'b0;
    asel_evt  = 1'b0;
    reset_evt = 1'b0;
    if (wr_en) begin
      if (state_q == S_PROG) begin
        prog_evt = 1'b1;
        state_d  = S_IDLE;
      end else if (wr_data == K_RESET) begin
        reset_evt = 1'b1;
        state_d   = S_IDLE;
      end else begin
        state_d = S_IDLE;
        unique case (state_q)
          S_IDLE: if (hit_a) state_d = S_UNL1;
          S_UNL1: if (hit_b) state_d = S_UNL2;
          S_UNL2: begin
            if (cmd_is(low, wr_data, K_PROG_SET))       state_d = S_PROG;
            else if (cmd_is(low, wr_data, K_ERASE_SET)) state_d = S_ERS1;
            else if (cmd_is(low, wr_data, K_IDENT))     asel_evt = 1'b1;
          end
          S_ERS1: if (hit_a) state_d = S_ERS2;
          S_ERS2: if (hit_b) state_d = S_ERS3;
          S_ERS3: if (cmd_is(low, wr_data, K_CHIP_ERS)) erase_evt = 1'b1;
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: an unrelated data byte outside the program-data step drops the sequence
  p_break_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state_q != S_PROG && wr_data != K_UNLOCK_A && wr_data != K_UNLOCK_B &&
     wr_data != K_PROG_SET && wr_data != K_ERASE_SET && wr_data != K_CHIP_ERS &&
     wr_data != K_IDENT) |=> (state_q == S_IDLE));

  p_evt_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_evt, erase_evt, asel_evt, reset_evt}));

  // R10: a reset byte always lands the sequencer in idle
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> (state_q == S_IDLE));

endmodule

// File: rtl/fcd_launch.sv
module fcd_launch
  import fcd_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int SECT_BITS = 3,
  localparam int NSECT    = 1 << SECT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_evt,
  input  logic              erase_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NSECT-1:0]  sect_prot,
  output logic              prot_hit,
  output logic              op_start,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  function automatic logic sect_locked(input logic [ADDR_W-1:0] a,
                                       input logic [NSECT-1:0] p);
    return p[a[ADDR_W-1 -: SECT_BITS]];
  endfunction

  logic accept_prog;

  assign prot_hit    = sect_locked(wr_addr, sect_prot);
  assign accept_prog = prog_evt && !prot_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_start <= 1'b0;
      op_kind  <= OP_PROG;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_start <= accept_prog || erase_evt;
      if (accept_prog) begin
        op_kind <= OP_PROG;
        op_addr <= wr_addr;
        op_data <= wr_data;
      end else if (erase_evt) begin
        op_kind <= OP_ERASE;
        op_addr <= '0;
        op_data <= 8'hFF;
      end
    end
  end

  p_prot_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_evt && prot_hit) |=> !op_start);

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  p_hold_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_evt && !erase_evt) |=> ($stable(op_addr) && $stable(op_data)));

  p_erase_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_evt |=> (op_start && op_kind == OP_ERASE));

endmodule

// File: rtl/fcd_asel.sv
module fcd_asel
  import fcd_pkg::*;
#(
  parameter int          ADDR_W    = 17,
  parameter int          SECT_BITS = 3,
  parameter logic [6:0]  MFR_ID7   = 7'h01,
  parameter logic [6:0]  DEV_ID7   = 7'h20,
  localparam int         NSECT     = 1 << SECT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asel_evt,
  input  logic              reset_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  sect_prot,
  output logic              asel_mode,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  function automatic logic [7:0] ident_lookup(input logic [ADDR_W-1:0] a,
                                              input logic [NSECT-1:0] p);
    if (a[7:0] == 8'h00)      return odd_code(MFR_ID7);
    else if (a[7:0] == 8'h01) return odd_code(DEV_ID7);
    else if (a[1:0] == 2'b10) return {7'd0, p[a[ADDR_W-1 -: SECT_BITS]]};
    else                      return 8'h00;
  endfunction

  logic asel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         asel_q <= 1'b0;
    else if (reset_evt) asel_q <= 1'b0;
    else if (asel_evt)  asel_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_en && asel_q) begin
      rd_valid <= 1'b1;
      rd_data  <= ident_lookup(rd_addr, sect_prot);
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end

  assign asel_mode = asel_q;

  p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    asel_evt |=> asel_mode);

  p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> !asel_mode);

  p_rd_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en && asel_mode));

  p_odd_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_addr[7:1] == 7'd0)) |-> (^rd_data));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W    = 17,
  parameter int         CMD_AW    = 11,
  parameter int         SECT_BITS = 3,
  parameter logic [6:0] MFR_ID7   = 7'h01,
  parameter logic [6:0] DEV_ID7   = 7'h20,
  localparam int        NSECT     = 1 << SECT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [NSECT-1:0]  sect_prot,
  output logic              asel_mode,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              op_start,
  output logic              op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  logic       prog_evt, erase_evt, asel_evt, reset_evt, prot_hit;
  seq_state_e seq_state;
  op_kind_e   kind_w;

  fcd_seq #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .prog_evt(prog_evt), .erase_evt(erase_evt),
    .asel_evt(asel_evt), .reset_evt(reset_evt),
    .state_o(seq_state)
  );

  fcd_launch #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_launch (
    .clk(clk), .rst_n(rst_n),
    .prog_evt(prog_evt), .erase_evt(erase_evt),
    .wr_addr(bus_addr), .wr_data(bus_wdata), .sect_prot(sect_prot),
    .prot_hit(prot_hit),
    .op_start(op_start), .op_kind(kind_w),
    .op_addr(op_addr), .op_data(op_data)
  );

  fcd_asel #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
             .MFR_ID7(MFR_ID7), .DEV_ID7(DEV_ID7)) u_asel (
    .clk(clk), .rst_n(rst_n),
    .asel_evt(asel_evt), .reset_evt(reset_evt),
    .rd_en(bus_rd), .rd_addr(bus_addr), .sect_prot(sect_prot),
    .asel_mode(asel_mode), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign op_kind = kind_w;

  // R2: a program launch follows a write made while awaiting program data
  p_prog_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 1'b0) |-> $past(bus_wr && seq_state == S_PROG));

  // R4: the protect check happens at the data write
  p_prot_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 1'b0) |-> !$past(prot_hit));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] sect_prot = 8'b0000_0100;
  logic asel_mode, rd_valid, op_start, op_kind;
  logic [7:0] rd_data, op_data;
  logic [AW-1:0] op_addr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sect_prot(sect_prot),
    .asel_mode(asel_mode), .rd_valid(rd_valid), .rd_data(rd_data),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
  );

  // vector: [51:48] req, [47:44] kind 0=wr 1=rd, [43:24] addr, [23:16] data,
  //         [15:12] expected op 0=none 1=prog 2=erase, [11:8] expect read, [7:0] read value
  function automatic logic [51:0] W(input logic [3:0] rq, input logic [19:0] a,
                                    input logic [7:0] d, input logic [3:0] op);
    return {rq, 4'd0, a, d, op, 4'd0, 8'd0};
  endfunction

  function automatic logic [51:0] RD(input logic [3:0] rq, input logic [19:0] a,
                                     input logic [3:0] e, input logic [7:0] v);
    return {rq, 4'd1, a, 8'd0, 4'd0, e, v};
  endfunction

  localparam int NV = 51;
  localparam logic [51:0] VEC [NV] = '{
    // R2 program
    W(2, 20'h00555, 8'hAA, 0), W(2, 20'h002AA, 8'h55, 0), W(2, 20'h00555, 8'hA0, 0),
    W(2, 20'h01234, 8'h5A, 1),
    // R3 erase
    W(3, 20'h00555, 8'hAA, 0), W(3, 20'h002AA, 8'h55, 0), W(3, 20'h00555, 8'h80, 0),
    W(3, 20'h00555, 8'hAA, 0), W(3, 20'h002AA, 8'h55, 0), W(3, 20'h00555, 8'h10, 2),
    // R4 protected sector 2, then unprotected sector 3
    W(4, 20'h00555, 8'hAA, 0), W(4, 20'h002AA, 8'h55, 0), W(4, 20'h00555, 8'hA0, 0),
    W(4, 20'h08010, 8'h33, 0),
    W(4, 20'h00555, 8'hAA, 0), W(4, 20'h002AA, 8'h55, 0), W(4, 20'h00555, 8'hA0, 0),
    W(4, 20'h0C000, 8'h77, 1),
    // R5 broken sequence, then recovery
    W(5, 20'h00555, 8'hAA, 0), W(5, 20'h002AB, 8'h55, 0), W(5, 20'h00555, 8'hA0, 0),
    W(5, 20'h00100, 8'h11, 0),
    W(5, 20'h00555, 8'hAA, 0), W(5, 20'h002AA, 8'h55, 0), W(5, 20'h00555, 8'hA0, 0),
    W(5, 20'h00200, 8'h22, 1),
    // R1 command at wrong address
    W(1, 20'h00555, 8'hAA, 0), W(1, 20'h002AA, 8'h55, 0), W(1, 20'h00123, 8'h90, 0),
    RD(1, 20'h00000, 0, 8'h00),
    // R11 array-mode read
    RD(11, 20'h00001, 0, 8'h00),
    // R6 enter identification mode, R7 / R9 reads
    W(6, 20'h00555, 8'hAA, 0), W(6, 20'h002AA, 8'h55, 0), W(6, 20'h00555, 8'h90, 0),
    RD(7, 20'h00000, 1, 8'h01), RD(7, 20'h00001, 1, 8'h20),
    RD(9, 20'h08002, 1, 8'h01), RD(9, 20'h04002, 1, 8'h00),
    RD(9, 20'h1C102, 1, 8'h00), RD(7, 20'h00F00, 1, 8'h01),
    // R6 program while identification mode stays active
    W(6, 20'h00555, 8'hAA, 0), W(6, 20'h002AA, 8'h55, 0), W(6, 20'h00555, 8'hA0, 0),
    W(6, 20'h10000, 8'h99, 1), RD(6, 20'h00001, 1, 8'h20),
    // R10 reset byte at arbitrary address
    W(10, 20'h1ABCD, 8'hF0, 0), RD(10, 20'h00000, 0, 8'h00),
    // R10 reset byte aborts a partial sequence
    W(10, 20'h00555, 8'hAA, 0), W(10, 20'h002AA, 8'h55, 0), W(10, 20'h00000, 8'hF0, 0),
    W(10, 20'h00321, 8'h44, 0)
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge register it, sample on the next falling edge
  task automatic drive(input logic wr, input logic rd, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic run_vec(input logic [51:0] v);
    string rq;
    rq = rname(v[51:48]);
    drive(v[47:44] == 4'd0, v[47:44] == 4'd1, v[40:24], v[23:16]);
    if (v[47:44] == 4'd0) begin
      chk(rq, "op_start", 32'(op_start), 32'(v[15:12] != 4'd0));
      if (v[15:12] == 4'd1) begin
        chk(rq, "op_kind prog", 32'(op_kind), 32'd0);
        chk(rq, "op_addr", 32'(op_addr), 32'(v[40:24]));
        chk(rq, "op_data", 32'(op_data), 32'(v[23:16]));
      end else if (v[15:12] == 4'd2) begin
        chk(rq, "op_kind erase", 32'(op_kind), 32'd1);
      end
    end else begin
      chk(rq, "rd_valid", 32'(rd_valid), 32'(v[11:8] != 4'd0));
      if (v[11:8] != 4'd0) chk(rq, "rd_data", 32'(rd_data), 32'(v[7:0]));
    end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [AW-1:0] held_addr;
    repeat (3) @(negedge clk);
    // reset state
    chk("R12", "reset op_start", 32'(op_start), 32'd0);
    chk("R11", "reset rd_valid", 32'(rd_valid), 32'd0);
    chk("R6", "reset asel_mode", 32'(asel_mode), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R6 mode flag at the port, one edge after the mode command
    drive(1'b1, 1'b0, 17'h00555, 8'hAA);
    drive(1'b1, 1'b0, 17'h002AA, 8'h55);
    drive(1'b1, 1'b0, 17'h00555, 8'h90);
    chk("R6", "asel_mode set", 32'(asel_mode), 32'd1);

    // R8 odd parity of both identification codes
    drive(1'b0, 1'b1, 17'h00000, 8'h00);
    chk("R8", "mfr parity", 32'($countones(rd_data) % 2), 32'd1);
    drive(1'b0, 1'b1, 17'h00001, 8'h00);
    chk("R8", "dev parity", 32'($countones(rd_data) % 2), 32'd1);

    // R9 protect bit follows the input for a sector that was clear
    sect_prot = 8'b1000_0000;
    drive(1'b0, 1'b1, 17'h1C006, 8'h00);
    chk("R9", "sector 7 locked", 32'(rd_data), 32'h01);

    // R12 one-cycle pulse and held fields
    drive(1'b1, 1'b0, 17'h00555, 8'hAA);
    drive(1'b1, 1'b0, 17'h002AA, 8'h55);
    drive(1'b1, 1'b0, 17'h00555, 8'hA0);
    drive(1'b1, 1'b0, 17'h04444, 8'hC3);
    chk("R12", "pulse high", 32'(op_start), 32'd1);
    held_addr = op_addr;
    @(negedge clk);
    chk("R12", "pulse low next cycle", 32'(op_start), 32'd0);
    drive(1'b1, 1'b0, 17'h00777, 8'h12);
    chk("R12", "op_addr held", 32'(op_addr), 32'(held_addr));
    chk("R12", "op_data held", 32'(op_data), 32'hC3);

    // R10 leave the mode
    drive(1'b1, 1'b0, 17'h00000, 8'hF0);
    chk("R10", "asel_mode cleared", 32'(asel_mode), 32'd0);
    drive(1'b0, 1'b1, 17'h00000, 8'h00);
    chk("R11", "no read answer after exit", 32'(rd_valid), 32'd0);

    finish_run();
  end

endmodule